// File: doc/BRIEF.md
# Display controller register bank

This block is the register file of a display controller. A host reaches it over a simple 32-bit bus that carries a byte address. It stores these registers:

- five control words;
- three frame-buffer start addresses;
- red, green and blue lookup words;
- a dithering-mode word;
- a temporary-palette word;
- a panel-select word;
- three interrupt registers: pending, source pending and mask.

Each register trims its write data in its own way. The panel-select word always sets one fixed bit on a write.

From the stored words the block decodes a few fields for the rest of the display pipeline:

- display enable;
- pixel depth code;
- 5:6:5 palette format select;
- byte-order select;
- panel width and panel height, each held as size minus one.

A frame-complete pulse from the scan engine sets the frame-sync source bit. The pending register collects every unmasked source bit on each clock. One level interrupt output reports that any pending bit is set.

Top module: `lcd_regbank`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: Byte offsets are as follows; `addr_i[1:0]` is ignored.

  | Offset | Register |
  |---|---|
  | 0x00 | control 1 |
  | 0x04 | control 2 |
  | 0x08 | control 3 |
  | 0x0C | control 4 |
  | 0x10 | control 5 |
  | 0x14 | start address 1 |
  | 0x18 | start address 2 |
  | 0x1C | start address 3 |
  | 0x20 | red lookup |
  | 0x24 | green lookup |
  | 0x28 | blue lookup |
  | 0x4C | dither |
  | 0x50 | temporary palette |
  | 0x54 | pending |
  | 0x58 | source pending |
  | 0x5C | mask |
  | 0x60 | panel select |

- R3: A write keeps only these bits; all other registers keep all 32 bits.

  | Register | Bits kept |
  |---|---|
  | control 1 | [17:0] |
  | control 4 | [15:0] |
  | control 5 | [12:0] |
  | blue lookup | [15:0] |
  | pending | [1:0] |
  | source pending | [1:0] |
  | mask | [2:0] |

- R4: A write to panel select keeps data bits [1:0] and sets bit 2 to one whatever the data.
- R5: Decoded fields:
  - `enable_o` is control 1 bit 0.
  - `depth_o` is control 1 bits [4:1].
  - `fmt565_o` is control 5 bit 11.
  - `byte_swap_o` is control 5 bit 12.
- R6: `height_o` is control 2 bits [23:14] plus one, 11 bits wide. `width_o` is control 3 bits [18:8] plus one, 12 bits wide.
- R7: On every clock, pending takes pending OR (source pending AND NOT mask[1:0]). A bus write to pending replaces this value with the written bits [1:0].
- R8: `frame_done_i` high at a clock edge sets source pending bit 1. This bit is ORed after a bus write to source pending in the same cycle.
- R9: `irq_o` is high exactly when a pending bit is set. It therefore rises one clock after a source or mask change that exposes a source bit.
- R10: A read of an unmapped offset returns zero, and a write to an unmapped offset changes no register.
- R11: `rdata_o` is registered. It shows the addressed value on the clock edge where `rd_en_i` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| frame_done_i | input | 1 | Frame-complete pulse |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt |
| enable_o | output | 1 | Display enable |
| depth_o | output | 4 | Pixel depth code |
| fmt565_o | output | 1 | 5:6:5 palette format select |
| byte_swap_o | output | 1 | Byte-order select |
| width_o | output | 12 | Panel width |
| height_o | output | 11 | Panel height |

## Verification
The bench builds the block with the default `ADDR_W` of 12. This width puts addresses such as 0x400 and 0xFFC inside the decoded space but outside the register map, so the full-address compare of the decoder is exercised, not only its low offset bits. Random traffic also sets the two ignored low address bits. This shows that each mapped register answers at all four byte lanes of its word.

// File: rtl/lcd_regbank_pkg.sv
package lcd_regbank_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_CFG  = 14;
  localparam int NUM_REGS = 17;

  localparam int RG_CTRL1 = 0;
  localparam int RG_CTRL2 = 1;
  localparam int RG_CTRL3 = 2;
  localparam int RG_CTRL4 = 3;
  localparam int RG_CTRL5 = 4;
  localparam int RG_SA1   = 5;
  localparam int RG_SA2   = 6;
  localparam int RG_SA3   = 7;
  localparam int RG_RED   = 8;
  localparam int RG_GRN   = 9;
  localparam int RG_BLU   = 10;
  localparam int RG_DITH  = 11;
  localparam int RG_TPAL  = 12;
  localparam int RG_PSEL  = 13;
  localparam int RG_IPND  = 14;
  localparam int RG_ISRC  = 15;
  localparam int RG_IMSK  = 16;

  localparam int IRQ_W     = 2;
  localparam int MSK_W     = 3;
  localparam int FRAME_BIT = 1;

  localparam int DEPTH_LSB  = 1;
  localparam int DEPTH_W    = 4;
  localparam int FMT565_BIT = 11;
  localparam int BSWAP_BIT  = 12;
  localparam int HEIGHT_LSB = 14;
  localparam int HEIGHT_W   = 10;
  localparam int WIDTH_LSB  = 8;
  localparam int WIDTH_W    = 11;
  localparam int HEIGHT_OUT_W = HEIGHT_W + 1;
  localparam int WIDTH_OUT_W  = WIDTH_W + 1;

  function automatic logic [7:0] reg_offset(int id);
    case (id)
      RG_CTRL1: return 8'h00;
      RG_CTRL2: return 8'h04;
      RG_CTRL3: return 8'h08;
      RG_CTRL4: return 8'h0C;
      RG_CTRL5: return 8'h10;
      RG_SA1:   return 8'h14;
      RG_SA2:   return 8'h18;
      RG_SA3:   return 8'h1C;
      RG_RED:   return 8'h20;
      RG_GRN:   return 8'h24;
      RG_BLU:   return 8'h28;
      RG_DITH:  return 8'h4C;
      RG_TPAL:  return 8'h50;
      RG_PSEL:  return 8'h60;
      RG_IPND:  return 8'h54;
      RG_ISRC:  return 8'h58;
      default:  return 8'h5C;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] keep_mask(int id);
    case (id)
      RG_CTRL1: return 32'h0003_FFFF;
      RG_CTRL4: return 32'h0000_FFFF;
      RG_CTRL5: return 32'h0000_1FFF;
      RG_BLU:   return 32'h0000_FFFF;
      RG_PSEL:  return 32'h0000_0003;
      default:  return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] force_mask(int id);
    return (id == RG_PSEL) ? 32'h0000_0004 : 32'h0;
  endfunction
endpackage

// File: rtl/lcd_addr_decode.sv
module lcd_addr_decode
  import lcd_regbank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] sel_o,
  output logic                hit_o
);
  logic unused_lsb;
  assign unused_lsb = ^addr_i[1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(reg_offset(g));
    assign sel_o[g] = (addr_i[ADDR_W-1:2] == OFF[ADDR_W-1:2]);
  end

  assign hit_o = |sel_o;
endmodule

// File: rtl/lcd_cfg_regs.sv
module lcd_cfg_regs
  import lcd_regbank_pkg::*;
(
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [NUM_CFG-1:0]               sel_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [NUM_CFG-1:0][DATA_W-1:0]   regs_o
);
  for (genvar g = 0; g < NUM_CFG; g++) begin : g_reg
    localparam logic [DATA_W-1:0] KEEP  = keep_mask(g);
    localparam logic [DATA_W-1:0] FORCE = force_mask(g);
    logic [DATA_W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 r_q <= '0;
      else if (wr_en_i && sel_i[g]) r_q <= (wdata_i & KEEP) | FORCE;
    end
    assign regs_o[g] = r_q;
  end

  p_ctrl1_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i[RG_CTRL1]) |=> (regs_o[RG_CTRL1][31:18] == '0));

  p_ctrl5_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i[RG_CTRL5]) |=> (regs_o[RG_CTRL5][31:13] == '0));

  p_psel_force_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i[RG_PSEL]) |=> (regs_o[RG_PSEL][2] && regs_o[RG_PSEL][31:3] == '0));
endmodule

// File: rtl/lcd_irq_ctrl.sv
module lcd_irq_ctrl
  import lcd_regbank_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             sel_pnd_i,
  input  logic             sel_src_i,
  input  logic             sel_msk_i,
  input  logic [MSK_W-1:0] wdata_i,
  input  logic             frame_done_i,
  output logic [IRQ_W-1:0] pnd_o,
  output logic [IRQ_W-1:0] src_o,
  output logic [MSK_W-1:0] msk_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] pnd_q, src_q, frame_set, exposed;
  logic [MSK_W-1:0] msk_q;

  assign frame_set = IRQ_W'(frame_done_i) << FRAME_BIT;
  assign exposed   = src_q & ~msk_q[IRQ_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pnd_q <= '0;
      src_q <= '0;
      msk_q <= '0;
    end else begin
      // source write first, frame pulse ORed on top
      src_q <= ((wr_en_i && sel_src_i) ? wdata_i[IRQ_W-1:0] : src_q) | frame_set;
      pnd_q <= (wr_en_i && sel_pnd_i) ? wdata_i[IRQ_W-1:0] : (pnd_q | exposed);
      if (wr_en_i && sel_msk_i) msk_q <= wdata_i;
    end
  end

  assign pnd_o = pnd_q;
  assign src_o = src_q;
  assign msk_o = msk_q;
  assign irq_o = |pnd_q;

  p_frame_sets_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_i |=> src_o[FRAME_BIT]);

  p_pnd_collect_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && sel_pnd_i) |=>
      ((pnd_o & $past(src_o & ~msk_o[IRQ_W-1:0])) == $past(src_o & ~msk_o[IRQ_W-1:0])));

  p_pnd_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && sel_pnd_i) |=> ((pnd_o & $past(pnd_o)) == $past(pnd_o)));

  p_irq_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_en_i && sel_pnd_i) && (src_o & ~msk_o[IRQ_W-1:0]) != '0) |=> irq_o);
endmodule

// File: rtl/lcd_regbank.sv
module lcd_regbank
  import lcd_regbank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic                    rd_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic                    frame_done_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    irq_o,
  output logic                    enable_o,
  output logic [DEPTH_W-1:0]      depth_o,
  output logic                    fmt565_o,
  output logic                    byte_swap_o,
  output logic [WIDTH_OUT_W-1:0]  width_o,
  output logic [HEIGHT_OUT_W-1:0] height_o
);
  logic [NUM_REGS-1:0]             sel;
  logic                            hit;
  logic [NUM_CFG-1:0][DATA_W-1:0]  cfg;
  logic [IRQ_W-1:0]                pnd, src;
  logic [MSK_W-1:0]                msk;
  logic [DATA_W-1:0]               rd_mux, rdata_q;

  lcd_addr_decode #(.ADDR_W(ADDR_W)) i_dec (
    .addr_i (addr_i),
    .sel_o  (sel),
    .hit_o  (hit)
  );

  lcd_cfg_regs i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .sel_i   (sel[NUM_CFG-1:0]),
    .wdata_i (wdata_i),
    .regs_o  (cfg)
  );

  lcd_irq_ctrl i_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .sel_pnd_i    (sel[RG_IPND]),
    .sel_src_i    (sel[RG_ISRC]),
    .sel_msk_i    (sel[RG_IMSK]),
    .wdata_i      (wdata_i[MSK_W-1:0]),
    .frame_done_i (frame_done_i),
    .pnd_o        (pnd),
    .src_o        (src),
    .msk_o        (msk),
    .irq_o        (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CFG; i++)
      if (sel[i]) rd_mux = rd_mux | cfg[i];
    if (sel[RG_IPND]) rd_mux = rd_mux | DATA_W'(pnd);
    if (sel[RG_ISRC]) rd_mux = rd_mux | DATA_W'(src);
    if (sel[RG_IMSK]) rd_mux = rd_mux | DATA_W'(msk);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= hit ? rd_mux : '0;
  end
  assign rdata_o = rdata_q;

  assign enable_o    = cfg[RG_CTRL1][0];
  assign depth_o     = cfg[RG_CTRL1][DEPTH_LSB +: DEPTH_W];
  assign fmt565_o    = cfg[RG_CTRL5][FMT565_BIT];
  assign byte_swap_o = cfg[RG_CTRL5][BSWAP_BIT];
  assign height_o    = {1'b0, cfg[RG_CTRL2][HEIGHT_LSB +: HEIGHT_W]} + HEIGHT_OUT_W'(1);
  assign width_o     = {1'b0, cfg[RG_CTRL3][WIDTH_LSB +: WIDTH_W]} + WIDTH_OUT_W'(1);

  p_sel_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));

  p_unmapped_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !hit) |=> (rdata_o == '0));

  p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

  p_unmapped_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hit) |=> $stable(cfg));
endmodule

// File: tb/test_lcd_regbank.sv
module test_lcd_regbank;
  localparam int ADDR_W = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, frame_done = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_o;
  logic        irq_o, enable_o, fmt565_o, byte_swap_o;
  logic [3:0]  depth_o;
  logic [11:0] width_o;
  logic [10:0] height_o;

  int n_chk = 0, n_err = 0;
  bit irq_chk_en = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lcd_regbank #(.ADDR_W(ADDR_W)) i_lcd_regbank (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .frame_done_i(frame_done),
    .rdata_o(rdata_o), .irq_o(irq_o), .enable_o(enable_o), .depth_o(depth_o),
    .fmt565_o(fmt565_o), .byte_swap_o(byte_swap_o),
    .width_o(width_o), .height_o(height_o)
  );

  // model storage indexed by byte offset [6:2]
  logic [31:0] m [0:24];

  function automatic bit is_mapped(logic [ADDR_W-1:0] a);
    int ix = int'(a[6:2]);
    if (a[ADDR_W-1:7] != '0) return 1'b0;
    return (ix <= 10) || (ix >= 19 && ix <= 24);
  endfunction

  function automatic logic [31:0] keep_of(int ix);
    case (ix)
      0:      return 32'h0003_FFFF;
      3:      return 32'h0000_FFFF;
      4:      return 32'h0000_1FFF;
      10:     return 32'h0000_FFFF;
      21, 22: return 32'h3;
      23:     return 32'h7;
      24:     return 32'h3;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] pick_addr(int k);
    logic [7:0] off;
    case (k)
      0: off = 8'h00;  1: off = 8'h04;  2: off = 8'h08;  3: off = 8'h0C;
      4: off = 8'h10;  5: off = 8'h14;  6: off = 8'h18;  7: off = 8'h1C;
      8: off = 8'h20;  9: off = 8'h24;  10: off = 8'h28; 11: off = 8'h4C;
      12: off = 8'h50; 13: off = 8'h54; 14: off = 8'h58; 15: off = 8'h5C;
      16: off = 8'h60; 17: off = 8'h2C;
      18: return 12'h400;
      default: return 12'hFFC;
    endcase
    return ADDR_W'(off);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= 24; i++) m[i] <= '0;
    end else begin
      logic w;
      int ix;
      logic [1:0] src_n, pnd_n;
      w = wr_en && is_mapped(addr);
      ix = int'(addr[6:2]);
      src_n = (w && ix == 22) ? wdata[1:0] : m[22][1:0];
      src_n[1] = src_n[1] | frame_done;
      pnd_n = (w && ix == 21) ? wdata[1:0] : (m[21][1:0] | (m[22][1:0] & ~m[23][1:0]));
      m[21] <= {30'b0, pnd_n};
      m[22] <= {30'b0, src_n};
      if (w && ix != 21 && ix != 22)
        m[ix] <= (wdata & keep_of(ix)) | ((ix == 24) ? 32'h4 : 32'h0);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (irq_chk_en && !finished)
      chk(irq_o == |m[21][1:0], "R9 irq level", 32'(irq_o), 32'(|m[21][1:0]));

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input string req);
    logic [31:0] exp;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp = is_mapped(a) ? m[int'(a[6:2])] : 32'h0;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rdata_o == exp, req, rdata_o, exp);
  endtask

  task automatic read_expect(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rdata_o == exp, req, rdata_o, exp);
  endtask

  task automatic check_fields();
    logic [10:0] eh;
    logic [11:0] ew;
    eh = {1'b0, m[1][23:14]} + 11'd1;
    ew = {1'b0, m[2][18:8]} + 12'd1;
    chk(enable_o == m[0][0], "R5 enable", 32'(enable_o), 32'(m[0][0]));
    chk(depth_o == m[0][4:1], "R5 depth", 32'(depth_o), 32'(m[0][4:1]));
    chk(fmt565_o == m[4][11], "R5 fmt565", 32'(fmt565_o), 32'(m[4][11]));
    chk(byte_swap_o == m[4][12], "R5 byte order", 32'(byte_swap_o), 32'(m[4][12]));
    chk(height_o == eh, "R6 height", 32'(height_o), 32'(eh));
    chk(width_o == ew, "R6 width", 32'(width_o), 32'(ew));
  endtask

  task automatic pulse_frame();
    @(negedge clk);
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(irq_o == 1'b0, "R1 irq after reset", 32'(irq_o), 32'h0);
    for (int k = 0; k < 17; k++) read_expect(pick_addr(k), 32'h0, "R1 reset value");
    irq_chk_en = 1'b1;

    // R3 R4 keep masks with all-ones data
    for (int k = 0; k < 17; k++) do_write(pick_addr(k), 32'hFFFF_FFFF);
    read_expect(12'h000, 32'h0003_FFFF, "R3 ctrl1 keep");
    read_expect(12'h00C, 32'h0000_FFFF, "R3 ctrl4 keep");
    read_expect(12'h010, 32'h0000_1FFF, "R3 ctrl5 keep");
    read_expect(12'h028, 32'h0000_FFFF, "R3 blue keep");
    read_expect(12'h05C, 32'h0000_0007, "R3 mask keep");
    read_expect(12'h004, 32'hFFFF_FFFF, "R3 ctrl2 full");
    read_expect(12'h060, 32'h0000_0007, "R4 panel select ones");
    do_write(12'h060, 32'h0);
    read_expect(12'h060, 32'h0000_0004, "R4 panel select forced bit");
    for (int k = 0; k < 17; k++) do_read(pick_addr(k), "R2 readback");

    // R5 R6 field decode corners
    do_write(12'h000, 32'h0000_001B);
    do_write(12'h004, 32'h0);
    do_write(12'h008, 32'h0007_FF00);
    do_write(12'h010, 32'h0000_0800);
    check_fields();
    chk(depth_o == 4'hD, "R5 depth code", 32'(depth_o), 32'hD);
    chk(height_o == 11'd1, "R6 min height", 32'(height_o), 32'd1);
    chk(width_o == 12'd2048, "R6 max width", 32'(width_o), 32'd2048);
    do_write(12'h004, 32'h00FF_C000);
    do_write(12'h010, 32'h0000_1000);
    check_fields();
    chk(height_o == 11'd1024, "R6 max height", 32'(height_o), 32'd1024);

    // R2 low address bits ignored
    do_write(12'h017, 32'hA5A5_1234);
    read_expect(12'h014, 32'hA5A5_1234, "R2 lane ignored");

    // R10 unmapped access
    do_write(12'h02C, 32'hDEAD_BEEF);
    do_write(12'h400, 32'hDEAD_BEEF);
    do_write(12'h064, 32'hDEAD_BEEF);
    read_expect(12'h02C, 32'h0, "R10 unmapped read 0x2C");
    read_expect(12'h400, 32'h0, "R10 unmapped read 0x400");
    read_expect(12'hFFC, 32'h0, "R10 unmapped read 0xFFC");
    for (int k = 0; k < 17; k++) do_read(pick_addr(k), "R10 state unchanged");

    // R11 hold
    read_expect(12'h014, 32'hA5A5_1234, "R11 read value");
    repeat (3) @(negedge clk);
    chk(rdata_o == 32'hA5A5_1234, "R11 hold", rdata_o, 32'hA5A5_1234);

    // R7 R8 R9 interrupt timing
    do_write(12'h05C, 32'h0);
    do_write(12'h058, 32'h0);
    do_write(12'h054, 32'h0);
    chk(irq_o == 1'b0, "R9 cleared", 32'(irq_o), 32'h0);
    @(negedge clk);
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    chk(irq_o == 1'b0, "R9 one clock latency", 32'(irq_o), 32'h0);
    @(negedge clk);
    chk(irq_o == 1'b1, "R8 R9 frame raises irq", 32'(irq_o), 32'h1);
    read_expect(12'h058, 32'h2, "R8 source bit 1");
    read_expect(12'h054, 32'h2, "R7 pending bit 1");
    do_write(12'h054, 32'h0);
    chk(irq_o == 1'b0, "R7 pending write clears", 32'(irq_o), 32'h0);
    @(negedge clk);
    chk(irq_o == 1'b1, "R7 pending refills from source", 32'(irq_o), 32'h1);

    do_write(12'h05C, 32'h2);
    do_write(12'h058, 32'h0);
    do_write(12'h054, 32'h0);
    pulse_frame();
    repeat (4) @(negedge clk);
    chk(irq_o == 1'b0, "R7 masked source", 32'(irq_o), 32'h0);
    do_write(12'h05C, 32'h0);
    chk(irq_o == 1'b0, "R9 unmask latency", 32'(irq_o), 32'h0);
    @(negedge clk);
    chk(irq_o == 1'b1, "R9 unmask raises", 32'(irq_o), 32'h1);

    // R8 same-cycle write and frame pulse
    do_write(12'h05C, 32'h3);
    @(negedge clk);
    wr_en = 1'b1; addr = 12'h058; wdata = 32'h1; frame_done = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; frame_done = 1'b0;
    read_expect(12'h058, 32'h3, "R8 frame ORed over write");

    // random traffic
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [ADDR_W-1:0] a;
      op = int'($urandom_range(0, 9));
      a = pick_addr(int'($urandom_range(0, 19))) | ADDR_W'($urandom_range(0, 3));
      if (op < 4) do_write(a, $urandom());
      else if (op < 8) do_read(a, "R2 R3 random readback");
      else pulse_frame();
      if (op == 0) check_fields();
    end
    check_fields();

    @(negedge clk);
    irq_chk_en = 1'b0;
    finish_run();
  end
endmodule